// File: doc/BRIEF.md
# Microcontroller Sleep-Mode Controller

This block manages the two low-power states of a small 8-bit microcontroller. Software writes a two-bit mode field. Bit 0 requests idle and bit 1 requests power-down. In idle the CPU clock is gated off while the peripheral clock keeps running. In power-down the peripheral clock and the oscillator are both off. While the part sleeps, the block tells the pad logic to hold the address-latch strobe and the program-store strobe at fixed levels. Those levels are high in idle and low in power-down.

Idle ends on any enabled interrupt request. Power-down ends only through an external interrupt pin that is enabled and configured as level-sensitive. Pulling such a pin low turns the oscillator back on. The block then counts oscillator cycles while the pin stays low, and the wake completes only when the pin is released after the count has reached its terminal value. On every wake the block emits a one-cycle pulse and the index of the interrupt that caused it, so the interrupt logic can vector to the matching service routine. An asynchronous hardware reset returns the block to the running state from either mode.

Top module: `pwr_mode_ctl`

## Requirements
- R1: Writing the mode field with bit 0 set and bit 1 clear enters idle. In idle, `cpu_clk_en` is 0, `per_clk_en` and `osc_en` are 1, `strobe_hold` is 1 and `strobe_level` is 1. `mode_q` reads 2'b01.
- R2: Writing the mode field with bit 1 set enters power-down. In power-down with no qualifying pin low, `cpu_clk_en`, `per_clk_en`, `osc_en` and `strobe_level` are 0 and `strobe_hold` is 1. `mode_q` reads 2'b10.
- R3: If a single write sets both bits, power-down wins: `mode_q` reads 2'b10.
- R4: In idle, any set bit of `irq_pending` ends idle at the next clock edge. At that edge `wake_pulse` is 1 for exactly one cycle and `wake_src` holds the lowest set index.
- R5: In power-down, `irq_pending`, external pins configured as edge-triggered (`ext_level` bit 0) and disabled pins (`ext_en` bit 0) are ignored. The mode stays 2'b10 and `osc_en` stays 0.
- R6: In power-down, `osc_en` rises in the same cycle that a qualifying pin goes low. A qualifying pin is driven low on `ext_pin_n` and has both its `ext_en` and `ext_level` bits set.
- R7: Power-down ends at the first clock edge at which no qualifying pin is low, provided at least WAKE_CYCLES edges were counted with a pin low. At that edge `mode_q` becomes 2'b00 and `wake_pulse` is 1 for one cycle. External pin i reports as source index i.
- R8: If the pins are released after fewer than WAKE_CYCLES counted edges, `osc_en` drops and the part stays in power-down. The count restarts from zero, so a following low period must again last WAKE_CYCLES edges.
- R9: The low-cycle count saturates at WAKE_CYCLES. A pin held low far longer than required still wakes the part on release.
- R10: `wake_src` for a power-down wake is the lowest-index qualifying pin that was low when counting began.
- R11: Mode-field writes made while the part is asleep are ignored.
- R12: An active-low `rst_n` clears both mode bits, `wake_pulse` and `wake_src`, and restores all enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode write data: bit 0 idle, bit 1 power-down |
| irq_pending | input | NUM_IRQ | Enabled interrupt requests; indices below NUM_EXT are the external pins |
| ext_pin_n | input | NUM_EXT | External interrupt pins, active low |
| ext_en | input | NUM_EXT | Per-pin interrupt enable |
| ext_level | input | NUM_EXT | Per-pin trigger type: 1 level, 0 edge |
| mode_q | output | 2 | Current mode bits {power-down, idle} |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_hold | output | 1 | Bus strobes held at a fixed level |
| strobe_level | output | 1 | Level of the held strobes |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_src | output | SW | Index of the waking interrupt |

## Verification
The bench builds the block with WAKE_CYCLES = 8, NUM_IRQ = 4 and NUM_EXT = 2, so the low-time threshold can be crossed in a handful of cycles. At that size the bench can drive exact low times of 7 and 8 edges, a hold long enough to saturate the counter, and a retry after an early release. Four request lines are enough to test lowest-index selection across several patterns. Two pins are enough to mix qualifying pins with edge-configured and disabled ones.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int NUM_IRQ     = 8,
  parameter int NUM_EXT     = 2,
  parameter int WAKE_CYCLES = 1024,
  localparam int SW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int CW = $clog2(WAKE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_we,
  input  logic [1:0]         mode_wdata,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_EXT-1:0] ext_pin_n,
  input  logic [NUM_EXT-1:0] ext_en,
  input  logic [NUM_EXT-1:0] ext_level,
  output logic [1:0]         mode_q,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_en,
  output logic               strobe_hold,
  output logic               strobe_level,
  output logic               wake_pulse,
  output logic [SW-1:0]      wake_src
);
  localparam logic [CW-1:0] TERM = CW'(WAKE_CYCLES);

  logic          idle_q, pd_q, wake_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] src_q, wsrc_q, irq_first, ext_first;
  logic [NUM_EXT-1:0] ext_wake;

  assign ext_wake = ~ext_pin_n & ext_en & ext_level;
  wire pin_low = |ext_wake;
  wire asleep  = idle_q | pd_q;

  always_comb begin
    irq_first = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (irq_pending[i]) irq_first = SW'(i);
  end

  always_comb begin
    ext_first = '0;
    for (int i = NUM_EXT - 1; i >= 0; i--)
      if (ext_wake[i]) ext_first = SW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
      wake_q <= 1'b0;
      cnt_q  <= '0;
      src_q  <= '0;
      wsrc_q <= '0;
    end else begin
      wake_q <= 1'b0;
      if (!asleep) begin
        cnt_q <= '0;
        if (mode_we) begin
          pd_q   <= mode_wdata[1];
          idle_q <= mode_wdata[0] & ~mode_wdata[1];
        end
      end else if (idle_q) begin
        if (|irq_pending) begin
          idle_q <= 1'b0;
          wake_q <= 1'b1;
          wsrc_q <= irq_first;
        end
      end else if (pin_low) begin
        if (cnt_q == '0) src_q <= ext_first;
        if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q == TERM) begin
        pd_q   <= 1'b0;
        wake_q <= 1'b1;
        wsrc_q <= src_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign mode_q       = {pd_q, idle_q};
  assign cpu_clk_en   = ~asleep;
  assign per_clk_en   = ~pd_q;
  assign osc_en       = ~pd_q | pin_low;
  assign strobe_hold  = asleep;
  assign strobe_level = idle_q;
  assign wake_pulse   = wake_q;
  assign wake_src     = wsrc_q;

  a_r3_pd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && mode_we && mode_wdata == 2'b11) |=> (pd_q && !idle_q));

  a_r1_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_q && pd_q));

  a_r4_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> $past(asleep));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  a_r8_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && !pin_low && cnt_q != TERM) |=> (pd_q && cnt_q == '0));

  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);

  a_r11_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && mode_we && !wake_pulse && !(idle_q && |irq_pending) && !(pd_q && !pin_low && cnt_q == TERM))
      |=> $stable(mode_q));
endmodule

// File: tb/pwr_mode_ctl_bench.sv
module pwr_mode_ctl_bench;
  localparam int NI = 4, NE = 2, WC = 8, SW = 2;

  logic clk = 0, rst_n = 0, mode_we = 0;
  logic [1:0] mode_wdata = 0;
  logic [NI-1:0] irq_pending = 0;
  logic [NE-1:0] ext_pin_n = '1, ext_en = '1, ext_level = '1;
  logic [1:0] mode_q;
  logic cpu_clk_en, per_clk_en, osc_en, strobe_hold, strobe_level, wake_pulse;
  logic [SW-1:0] wake_src;
  int checks = 0, fails = 0;
  bit done = 0;

  pwr_mode_ctl #(.NUM_IRQ(NI), .NUM_EXT(NE), .WAKE_CYCLES(WC)) u_pwr_mode_ctl (
    .clk, .rst_n, .mode_we, .mode_wdata, .irq_pending, .ext_pin_n, .ext_en, .ext_level,
    .mode_q, .cpu_clk_en, .per_clk_en, .osc_en, .strobe_hold, .strobe_level,
    .wake_pulse, .wake_src);

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] d);
    mode_we = 1; mode_wdata = d;
    edges(1);
    mode_we = 0;
  endtask

  // {irq_pending, expected source}
  localparam logic [5:0] VEC [5] = '{
    {4'b0001, 2'd0}, {4'b0110, 2'd1}, {4'b1000, 2'd3}, {4'b1100, 2'd2}, {4'b1111, 2'd0}};

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    edges(2);
    chk("R12 mode", mode_q, 0);
    chk("R12 cpu", cpu_clk_en, 1);
    chk("R12 osc", osc_en, 1);
    chk("R12 pulse", wake_pulse, 0);
    rst_n = 1;
    edges(1);

    foreach (VEC[k]) begin
      wr(2'b01);
      chk("R1 mode", mode_q, 1);
      chk("R1 cpu", cpu_clk_en, 0);
      chk("R1 per", per_clk_en, 1);
      chk("R1 strobe", {strobe_hold, strobe_level}, 3);
      irq_pending = VEC[k][5:2];
      edges(1);
      irq_pending = 0;
      chk("R4 mode", mode_q, 0);
      chk("R4 pulse", wake_pulse, 1);
      chk("R4 src", wake_src, VEC[k][1:0]);
      edges(1);
      chk("R4 one cycle", wake_pulse, 0);
    end

    // R3 both bits -> power-down
    wr(2'b11);
    chk("R3 mode", mode_q, 2);
    chk("R2 enables", {cpu_clk_en, per_clk_en, osc_en}, 0);
    chk("R2 strobe", {strobe_hold, strobe_level}, 2);
    // R11 write while asleep
    wr(2'b01);
    chk("R11 mode", mode_q, 2);
    // R5 ignored sources
    irq_pending = 4'b1111;
    ext_level = 2'b10; ext_en = 2'b01; ext_pin_n = 2'b00;
    #1 chk("R5 osc", osc_en, 0);
    edges(WC + 3);
    chk("R5 mode", mode_q, 2);
    chk("R5 pulse", wake_pulse, 0);
    irq_pending = 0; ext_pin_n = 2'b11; ext_level = 2'b11; ext_en = 2'b11;
    edges(2);
    chk("R5 still asleep", mode_q, 2);

    // R8 early release after WC-1 edges
    ext_pin_n = 2'b10;
    #1 chk("R6 osc", osc_en, 1);
    edges(WC - 1);
    ext_pin_n = 2'b11;
    #1 chk("R8 osc drop", osc_en, 0);
    edges(1);
    chk("R8 mode", mode_q, 2);
    // retry: again WC-1 edges must fail (count restarted)
    ext_pin_n = 2'b10;
    edges(WC - 1);
    ext_pin_n = 2'b11;
    edges(2);
    chk("R8 restart", mode_q, 2);
    chk("R8 no pulse", wake_pulse, 0);

    // R7 exactly WC edges, pin 1 only
    ext_pin_n = 2'b01;
    edges(WC);
    chk("R7 before release", mode_q, 2);
    ext_pin_n = 2'b11;
    edges(1);
    chk("R7 mode", mode_q, 0);
    chk("R7 pulse", wake_pulse, 1);
    chk("R10 src pin1", wake_src, 1);
    chk("R7 cpu", cpu_clk_en, 1);

    // R9 long hold, both pins low -> src 0
    wr(2'b10);
    ext_pin_n = 2'b00;
    edges(3 * WC);
    ext_pin_n = 2'b11;
    edges(1);
    chk("R9 mode", mode_q, 0);
    chk("R9 pulse", wake_pulse, 1);
    chk("R10 src pin0", wake_src, 0);

    // R12 reset from power-down and from idle
    wr(2'b10);
    rst_n = 0;
    #1 chk("R12 pd reset", mode_q, 0);
    chk("R12 per", per_clk_en, 1);
    edges(1); rst_n = 1; edges(1);
    wr(2'b01);
    rst_n = 0;
    #1 chk("R12 idle reset", mode_q, 0);
    edges(1); rst_n = 1; edges(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule